// File: doc/BRIEF.md
# DDR3 Re-initialization Sequencer

This block lets host software re-run the DDR3 device bring-up at any time after boot without cycling power. Software first waits until the memory controller reports idle, then sets a reset control bit. The sequencer holds the DRAM reset line low and keeps clock enable low. It then releases reset and, after a further delay, raises clock enable. It waits out the exit-from-reset interval, hands control to an external mode register issuer, sends a long ZQ calibration command and waits for calibration to settle. Only then does it raise a done flag. The supply-ramp phase of a cold start is not part of the sequence.

While the sequence runs, a blocking output tells the rest of the controller to accept and issue no host traffic. The control bit clears itself when the sequence ends. A request made while the controller is busy is refused, and an error flag records the refusal. Every interval is given as a cycle count through a parameter.

Top module: `ddr3_reinit_seq`

## Requirements
- R1: After reset, `dram_reset_n_o` and `dram_cke_o` are high, and every other output is low.
- R2: A request (`req_set_i` high for one cycle) while the sequencer is at rest and `ctrl_idle_i` is high is accepted. From the next cycle, `ctl_bit_o` is high and `dram_reset_n_o` is low. A request while `ctrl_idle_i` is low starts nothing and sets `req_err_o`.
- R3: `dram_reset_n_o` stays low for exactly `RST_LOW_CYC` cycles, and `dram_cke_o` is low for that whole time.
- R4: After `dram_reset_n_o` rises, `dram_cke_o` stays low for exactly `CKE_LOW_CYC` cycles and then goes high.
- R5: After `dram_cke_o` rises, exactly `TXPR_CYC` cycles pass before `mrs_req_o` goes high.
- R6: `mrs_req_o` stays high until `mrs_done_i` is sampled high, and is low in the cycle after.
- R7: `zqcl_o` is high for exactly one cycle after the mode register handoff. It is followed by exactly `TZQINIT_CYC` cycles before `reinit_done_o` rises.
- R8: `host_block_o` is high from the cycle after acceptance until the cycle in which `reinit_done_o` rises, when it drops.
- R9: `ctl_bit_o` clears in the cycle in which `reinit_done_o` rises. `reinit_done_o` stays high until the next accepted request, which clears it.
- R10: A request that arrives while a sequence is running has no effect on the sequence or on `req_err_o`.
- R11: An accepted request clears `req_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_i | input | 1 | Host write that sets the reset control bit |
| ctrl_idle_i | input | 1 | The controller has no transfer in flight |
| mrs_done_i | input | 1 | The mode register issuer has finished |
| ctl_bit_o | output | 1 | Reset control bit as read back by the host |
| reinit_done_o | output | 1 | The sequence has completed |
| req_err_o | output | 1 | The last request was refused |
| host_block_o | output | 1 | Stop all host traffic |
| dram_reset_n_o | output | 1 | DRAM reset line, active low |
| dram_cke_o | output | 1 | DRAM clock enable |
| mrs_req_o | output | 1 | Request to the mode register issuer |
| zqcl_o | output | 1 | One-cycle long ZQ calibration command |

## Verification
The bench builds the sequencer with short intervals: 5 cycles of reset, 3 of clock enable low, 4 of exit wait and 6 of calibration wait. These are short enough to measure every phase of every run cycle by cycle. It sweeps the handoff response delay from zero to three cycles. Runs are interleaved with refused requests, requests made mid-sequence and back-to-back sequences. This covers the error flag, the done flag clearing, and the control bit clearing itself.

// File: rtl/ddr3rs_pkg.sv
package ddr3rs_pkg;

    typedef enum logic [2:0] {
        ST_REST   = 3'd0,
        ST_RSTLOW = 3'd1,
        ST_CKEW   = 3'd2,
        ST_XPR    = 3'd3,
        ST_MRS    = 3'd4,
        ST_ZQ     = 3'd5,
        ST_ZQW    = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       ctl;
        logic       done;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/ddr3rs_timer.sv
module ddr3rs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = len_i - CW'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > CW'(1)) |=> !zero_o); // R3
endmodule

// File: rtl/ddr3_reinit_seq.sv
module ddr3_reinit_seq
    import ddr3rs_pkg::*;
#(
    parameter int RST_LOW_CYC = 200,
    parameter int CKE_LOW_CYC = 500,
    parameter int TXPR_CYC    = 64,
    parameter int TZQINIT_CYC = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set_i,
    input  logic ctrl_idle_i,
    input  logic mrs_done_i,
    output logic ctl_bit_o,
    output logic reinit_done_o,
    output logic req_err_o,
    output logic host_block_o,
    output logic dram_reset_n_o,
    output logic dram_cke_o,
    output logic mrs_req_o,
    output logic zqcl_o
);
    localparam int MAX_A   = (RST_LOW_CYC > CKE_LOW_CYC) ? RST_LOW_CYC : CKE_LOW_CYC;
    localparam int MAX_B   = (TXPR_CYC > TZQINIT_CYC) ? TXPR_CYC : TZQINIT_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_LEN + 1);

    seq_regs_t     r_d, r_q;
    logic          t_load;
    logic [CW-1:0] t_len;
    logic          t_zero;

    ddr3rs_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .len_i  (t_len),
        .zero_o (t_zero)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_len  = '0;
        unique case (r_q.st)
            ST_REST: begin
                if (req_set_i) begin
                    if (ctrl_idle_i) begin
                        r_d.st   = ST_RSTLOW;
                        r_d.ctl  = 1'b1;
                        r_d.done = 1'b0;
                        r_d.err  = 1'b0;
                        t_load   = 1'b1;
                        t_len    = CW'(RST_LOW_CYC);
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_RSTLOW: if (t_zero) begin
                r_d.st = ST_CKEW;
                t_load = 1'b1;
                t_len  = CW'(CKE_LOW_CYC);
            end
            ST_CKEW: if (t_zero) begin
                r_d.st = ST_XPR;
                t_load = 1'b1;
                t_len  = CW'(TXPR_CYC);
            end
            ST_XPR: if (t_zero) r_d.st = ST_MRS;
            ST_MRS: if (mrs_done_i) r_d.st = ST_ZQ;
            ST_ZQ: begin
                r_d.st = ST_ZQW;
                t_load = 1'b1;
                t_len  = CW'(TZQINIT_CYC);
            end
            ST_ZQW: if (t_zero) begin
                r_d.st   = ST_REST;
                r_d.done = 1'b1;
                r_d.ctl  = 1'b0;
            end
            default: r_d.st = ST_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_REST;
            r_q.ctl  <= 1'b0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_bit_o      = r_q.ctl;
    assign reinit_done_o  = r_q.done;
    assign req_err_o      = r_q.err;
    assign host_block_o   = (r_q.st != ST_REST);
    assign dram_reset_n_o = (r_q.st != ST_RSTLOW);
    assign dram_cke_o     = (r_q.st != ST_RSTLOW) && (r_q.st != ST_CKEW);
    assign mrs_req_o      = (r_q.st == ST_MRS);
    assign zqcl_o         = (r_q.st == ST_ZQ);

    AST_CKE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_reset_n_o |-> !dram_cke_o); // R3
    AST_CKE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_reset_n_o) |-> !dram_cke_o); // R4
    AST_MRS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_req_o && mrs_done_i) |=> (!mrs_req_o && zqcl_o)); // R6
    AST_ZQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        zqcl_o |=> !zqcl_o); // R7
    AST_BLOCK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_reset_n_o || !dram_cke_o || mrs_req_o || zqcl_o) |-> host_block_o); // R8
    AST_DONE_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_done_o |-> !ctl_bit_o); // R9
    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_block_o && !req_err_o) |=> !req_err_o); // R10
endmodule

// File: tb/ddr3_reinit_seq_test.sv
module ddr3_reinit_seq_test;
    localparam int RL = 5;
    localparam int CL = 3;
    localparam int TX = 4;
    localparam int TZ = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_set = 1'b0;
    logic idle = 1'b1;
    logic mrs_done = 1'b0;
    logic ctl, done, err, blk, rstn_o, cke, mrs_req, zqcl;
    int   total = 0;
    int   bad = 0;

    always #5 clk = ~clk;

    ddr3_reinit_seq #(.RST_LOW_CYC(RL), .CKE_LOW_CYC(CL), .TXPR_CYC(TX), .TZQINIT_CYC(TZ)) uut (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .ctrl_idle_i(idle),
        .mrs_done_i(mrs_done), .ctl_bit_o(ctl), .reinit_done_o(done),
        .req_err_o(err), .host_block_o(blk), .dram_reset_n_o(rstn_o),
        .dram_cke_o(cke), .mrs_req_o(mrs_req), .zqcl_o(zqcl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        req_set = 1'b1;
        @(negedge clk);
        req_set = 1'b0;
    endtask

    task automatic run_seq(input int dly, input bit poke);
        int c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, c5 = 0, nb = 0, nc = 0;
        pulse_req();
        chk("R2 reset low after accept", int'(rstn_o), 0);
        chk("R9 done cleared by accept", int'(done), 0);
        chk("R11 err cleared by accept", int'(err), 0);
        for (int i = 0; i < 500 && !done; i++) begin
            if (!blk) nb++;
            if (!ctl) nc++;
            if (!rstn_o) begin
                c0++;
                if (cke) chk("R3 cke low in reset", 1, 0);
            end else if (!cke) c1++;
            else if (mrs_req) c3++;
            else if (zqcl) c4++;
            else if (blk) begin
                if (c3 == 0) c2++; else c5++;
            end
            mrs_done = mrs_req && (c3 == dly + 1);
            req_set = poke && (c2 == 1) && !mrs_req && cke && c3 == 0;
            @(negedge clk);
        end
        mrs_done = 1'b0;
        req_set = 1'b0;
        chk("R3 reset low cycles", c0, RL);
        chk("R4 cke low after release", c1, CL);
        chk("R5 txpr cycles", c2, TX);
        chk("R6 mrs request cycles", c3, dly + 1);
        chk("R7 zqcl cycles", c4, 1);
        chk("R7 zq init wait", c5, TZ);
        chk("R8 block held during run", nb, 0);
        chk("R8 block dropped at done", int'(blk), 0);
        chk("R9 ctl held during run", nc, 0);
        chk("R9 ctl self cleared", int'(ctl), 0);
        chk("R9 done raised", int'(done), 1);
        chk("R10 no err from busy request", int'(err), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset_n", int'(rstn_o), 1);
        chk("R1 cke", int'(cke), 1);
        chk("R1 block", int'(blk), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 ctl", int'(ctl), 0);
        chk("R1 mrs", int'(mrs_req), 0);
        chk("R1 zq", int'(zqcl), 0);

        for (int d = 0; d < 4; d++) begin
            idle = 1'b0;
            pulse_req();
            chk("R2 refused keeps reset high", int'(rstn_o), 1);
            chk("R2 refused no block", int'(blk), 0);
            chk("R2 refused sets err", int'(err), 1);
            chk("R2 refused no ctl", int'(ctl), 0);
            chk("R9 done kept after refusal", int'(done), (d == 0) ? 0 : 1);
            idle = 1'b1;
            run_seq(d, d[0]);
            repeat (d) @(negedge clk);
            chk("R9 done holds at rest", int'(done), 1);
        end
        run_seq(2, 1'b1);
        run_seq(0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule